// File: doc/BRIEF.md
# Pseudo-static RAM power-up sequencer

This block sits on the controller side of an external pseudo-static RAM and owns the device's chip-select and mode pins from the moment supply power is applied until the memory may be used. It waits for a power-good indication and then walks the pins through a fixed order. The mode pin stays low while chip select is pulled low for a minimum hold. Chip select then rises while the mode pin is still low, and the mode pin rises after it. Both pins then stay high for a second minimum hold. Both minimum intervals are given in microseconds and turned into clock-cycle counts from a clock-frequency parameter. The conversion rounds up, so a minimum can never be cut short.

The device forgets its partial-refresh size whenever power is removed. Every power-up therefore ends in a request state. The block presents the refresh size it captured, raises a request flag, and waits for the mode-write logic to acknowledge that the size has been written. Only then does it raise ready. If power-good drops in any state, the block returns to idle pins, clears ready, and runs the whole sequence again, including the refresh-size request. The power-good input is asynchronous and passes through a synchronizer chain.

Top module: `psram_pwrup_seq`

## Requirements
- R1: While reset is asserted, and while the synchronized power-good is low, psram_cs_n is 1, psram_mode is 0, and mset_req and ready are both 0.
- R2: After pwr_good rises, psram_cs_n goes low exactly SYNC_STAGES+1 rising clock edges later, counting the edge that first samples pwr_good high.
- R3: psram_cs_n stays low with psram_mode low for exactly ceil(MODE_LOW_US x CLK_HZ / 1e6) cycles. The count is never less than 1.
- R4: Chip select rises first. For exactly one cycle psram_cs_n is 1 while psram_mode is still 0, and psram_mode rises on the next edge.
- R5: Once psram_mode is high, both pins stay high for exactly ceil(MODE_HIGH_US x CLK_HZ / 1e6) cycles before mset_req asserts.
- R6: mset_req stays high until rsize_ack is sampled high in a cycle where mset_req is high. On that edge mset_req falls and ready rises.
- R7: rsize_ack is ignored outside the request state. Holding it high during the high hold neither shortens the hold nor skips the request.
- R8: rsize_sel is captured on the edge where mset_req rises, and rsize_out holds that value until the next capture. Later changes of rsize_sel are ignored. The encoding is 00 = 16 Mbit, 01 = 8 Mbit, 10 = 4 Mbit, 11 = no refresh region.
- R9: When pwr_good falls, the pins return to the R1 state on the SYNC_STAGES+1-th edge, and ready and mset_req clear. On the next power-up the full sequence runs again, including a new refresh-size request.
- R10: The mode pin is never high while chip select is low, and ready is only high while both pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Asynchronous supply-valid indication |
| rsize_sel | input | 2 | Requested partial-refresh size code |
| rsize_ack | input | 1 | Refresh size has been written to the device |
| psram_cs_n | output | 1 | Active-low chip select to the memory |
| psram_mode | output | 1 | Mode pin to the memory |
| rsize_out | output | 2 | Captured refresh size code to be written |
| mset_req | output | 1 | Refresh size must be written to the device |
| ready | output | 1 | Normal accesses are allowed |

## Verification
The bench builds the block with CLK_HZ = 130000 and the default intervals of 50 us and 200 us, with two synchronizer stages. At that clock the low hold works out to 6.5 cycles, so the round-up rule in R3 shows up as 7 cycles. The high hold is exactly 26 cycles. The whole power-up sequence, including the power-loss restart and the reset in the middle of a hold, therefore runs through several times in a few hundred cycles. The default 100 MHz build would need tens of thousands of cycles per power-up.

// File: rtl/psram_pwrup_pkg.sv
package psram_pwrup_pkg;

  // Sequencer states; order follows the required pin sequence.
  typedef enum logic [2:0] {
    ST_PWR_WAIT  = 3'd0,
    ST_LOW_HOLD  = 3'd1,
    ST_CS_RISE   = 3'd2,
    ST_HIGH_HOLD = 3'd3,
    ST_SIZE_REQ  = 3'd4,
    ST_RUN       = 3'd5
  } seq_state_t;

  // Partial-refresh size codes.
  typedef enum logic [1:0] {
    RS_16M  = 2'b00,
    RS_8M   = 2'b01,
    RS_4M   = 2'b10,
    RS_NONE = 2'b11
  } rsize_t;

  // Microseconds to clock cycles, rounded up, at least one cycle.
  function automatic longint unsigned us_to_cycles(
    input longint unsigned hz,
    input longint unsigned us
  );
    longint unsigned prod;
    longint unsigned cyc;
    prod = hz * us;
    cyc  = (prod + 64'd999_999) / 64'd1_000_000;
    if (cyc == 64'd0) cyc = 64'd1;
    return cyc;
  endfunction

endpackage

// File: rtl/psram_pwrup_sync.sv
// Synchronizer chain for the asynchronous power-good input.
module psram_pwrup_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/psram_pwrup_timer.sv
// Cycles-in-state counter: cleared on restart, saturates at all ones.
module psram_pwrup_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart || (cnt != {CNT_W{1'b1}});
    cnt_d  = restart ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

endmodule

// File: rtl/psram_pwrup_fsm.sv
// Pin-ordering state machine.
module psram_pwrup_fsm
  import psram_pwrup_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_ok,
  input  logic             size_ack,
  input  logic [31:0]      low_lim,
  input  logic [31:0]      high_lim,
  input  logic [CNT_W-1:0] hold_cnt,
  output logic             hold_restart,
  output logic             size_capture,
  output logic             cs_n,
  output logic             mode,
  output logic             size_req,
  output logic             run
);

  seq_state_t state_q, state_d;
  logic       low_done, high_done;

  always_comb begin
    low_done  = (32'(hold_cnt) == (low_lim  - 32'd1));
    high_done = (32'(hold_cnt) == (high_lim - 32'd1));
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    if (!pg_ok) begin
      state_d = ST_PWR_WAIT;
    end else begin
      unique case (state_q)
        ST_PWR_WAIT:  state_d = ST_LOW_HOLD;
        ST_LOW_HOLD:  if (low_done)  state_d = ST_CS_RISE;
        ST_CS_RISE:   state_d = ST_HIGH_HOLD;
        ST_HIGH_HOLD: if (high_done) state_d = ST_SIZE_REQ;
        ST_SIZE_REQ:  if (size_ack)  state_d = ST_RUN;
        ST_RUN:       state_d = ST_RUN;
        default:      state_d = ST_PWR_WAIT;
      endcase
    end
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PWR_WAIT;
    else        state_q <= state_d;
  end

  // Hold counter restarts on every state change.
  assign hold_restart = (state_d != state_q);
  assign size_capture = (state_q == ST_HIGH_HOLD) && (state_d == ST_SIZE_REQ);

  // Pin decode
  always_comb begin
    cs_n     = 1'b1;
    mode     = 1'b0;
    size_req = 1'b0;
    run      = 1'b0;
    unique case (state_q)
      ST_PWR_WAIT:  ;
      ST_LOW_HOLD:  cs_n = 1'b0;
      ST_CS_RISE:   ;
      ST_HIGH_HOLD: mode = 1'b1;
      ST_SIZE_REQ: begin
        mode     = 1'b1;
        size_req = 1'b1;
      end
      ST_RUN: begin
        mode = 1'b1;
        run  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/psram_rsize_hold.sv
// Holds the refresh-size code captured when the request opens.
module psram_rsize_hold
  import psram_pwrup_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   capture,
  input  rsize_t sel,
  output rsize_t held
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= RS_16M;
    else if (capture) held <= sel;
  end

endmodule

// File: rtl/psram_pwrup_seq.sv
// Top: power-up sequencer for an external pseudo-static RAM.
module psram_pwrup_seq
  import psram_pwrup_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned MODE_LOW_US  = 50,
  parameter int unsigned MODE_HIGH_US = 200,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic [1:0] rsize_sel,
  input  logic       rsize_ack,
  output logic       psram_cs_n,
  output logic       psram_mode,
  output logic [1:0] rsize_out,
  output logic       mset_req,
  output logic       ready
);

  localparam int unsigned LOW_CYC  = 32'(us_to_cycles(64'(CLK_HZ), 64'(MODE_LOW_US)));
  localparam int unsigned HIGH_CYC = 32'(us_to_cycles(64'(CLK_HZ), 64'(MODE_HIGH_US)));
  localparam int unsigned MAX_CYC  = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  logic             pg_sync;
  logic             hold_restart;
  logic             size_capture;
  logic [CNT_W-1:0] hold_cnt;
  logic [31:0]      low_lim;
  logic [31:0]      high_lim;
  rsize_t           size_held;

  assign low_lim  = LOW_CYC;
  assign high_lim = HIGH_CYC;

  psram_pwrup_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pwr_good),
    .q_sync  (pg_sync)
  );

  psram_pwrup_timer #(.CNT_W(CNT_W)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (hold_restart),
    .cnt     (hold_cnt)
  );

  psram_pwrup_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pg_ok        (pg_sync),
    .size_ack     (rsize_ack),
    .low_lim      (low_lim),
    .high_lim     (high_lim),
    .hold_cnt     (hold_cnt),
    .hold_restart (hold_restart),
    .size_capture (size_capture),
    .cs_n         (psram_cs_n),
    .mode         (psram_mode),
    .size_req     (mset_req),
    .run          (ready)
  );

  psram_rsize_hold i_rsize (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (size_capture),
    .sel     (rsize_t'(rsize_sel)),
    .held    (size_held)
  );

  assign rsize_out = size_held;

endmodule

// File: rtl/psram_pwrup_chk.sv
// Property checker for psram_pwrup_seq.
module psram_pwrup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pg_sync,
  input logic        psram_cs_n,
  input logic        psram_mode,
  input logic        mset_req,
  input logic        ready,
  input logic        rsize_ack,
  input logic [1:0]  rsize_out,
  input logic [31:0] low_lim,
  input logic [31:0] high_lim
);

  logic [31:0] low_run, last_low, high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      last_low <= '0;
      high_run <= '0;
    end else begin
      if (!psram_cs_n) begin
        low_run <= low_run + 32'd1;
      end else begin
        low_run <= '0;
        if (low_run != 32'd0) last_low <= low_run;
      end
      if (psram_mode && !mset_req) high_run <= high_run + 32'd1;
      else if (!psram_mode)        high_run <= '0;
    end
  end

  // R10
  mode_over_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psram_mode |-> psram_cs_n);

  // R10
  ready_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (psram_mode && psram_cs_n));

  // R4
  cs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psram_mode) |-> ($past(psram_cs_n) && !$past(psram_mode)));

  // R3
  low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psram_mode) |-> (last_low >= low_lim));

  // R5
  high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mset_req) |-> (high_run >= high_lim));

  // R6
  ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mset_req && rsize_ack && pg_sync) |=> (ready && !mset_req));

  // R8
  size_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mset_req && $past(mset_req)) |-> $stable(rsize_out));

  // R9
  power_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_sync |=> (!ready && !mset_req && psram_cs_n && !psram_mode));

endmodule

bind psram_pwrup_seq psram_pwrup_chk i_pwrup_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pg_sync    (pg_sync),
  .psram_cs_n (psram_cs_n),
  .psram_mode (psram_mode),
  .mset_req   (mset_req),
  .ready      (ready),
  .rsize_ack  (rsize_ack),
  .rsize_out  (rsize_out),
  .low_lim    (low_lim),
  .high_lim   (high_lim)
);

// File: tb/test_psram_pwrup_seq.sv
module test_psram_pwrup_seq;

  localparam int CLK_PERIOD = 10;
  // 130 kHz: 50 us -> 6.5 -> 7 cycles, 200 us -> 26 cycles.
  localparam int EXP_LOW  = 7;
  localparam int EXP_HIGH = 26;
  localparam int EXP_LAT  = 3;   // two sync stages plus the state edge

  typedef struct packed {
    logic [1:0] sel;
    logic [3:0] wait_cyc;
    logic       early;
  } vec_t;

  // 00=16M, 01=8M, 10=4M, 11=none
  localparam vec_t VECS [4] = '{
    '{sel: 2'b00, wait_cyc: 4'd0, early: 1'b0},
    '{sel: 2'b01, wait_cyc: 4'd3, early: 1'b1},
    '{sel: 2'b10, wait_cyc: 4'd1, early: 1'b0},
    '{sel: 2'b11, wait_cyc: 4'd5, early: 1'b1}
  };

  logic       clk;
  logic       rst_n;
  logic       pwr_good;
  logic [1:0] rsize_sel;
  logic       rsize_ack;
  logic       psram_cs_n;
  logic       psram_mode;
  logic [1:0] rsize_out;
  logic       mset_req;
  logic       ready;

  int  checks;
  int  errors;
  bit  finished;

  psram_pwrup_seq #(
    .CLK_HZ       (130_000),
    .MODE_LOW_US  (50),
    .MODE_HIGH_US (200),
    .SYNC_STAGES  (2)
  ) i_psram_pwrup_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .rsize_sel  (rsize_sel),
    .rsize_ack  (rsize_ack),
    .psram_cs_n (psram_cs_n),
    .psram_mode (psram_mode),
    .rsize_out  (rsize_out),
    .mset_req   (mset_req),
    .ready      (ready)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, {psram_cs_n, psram_mode, mset_req, ready}, 4'b1000);
  endtask

  // Raise power and walk up to the request state, measuring each phase.
  task automatic run_up(input logic [1:0] sel, input bit early);
    int n;
    rsize_sel = sel;
    pwr_good  = 1'b1;
    n = 0;
    do begin step(); n++; end while (psram_cs_n && n < 50);
    check("R2 latency to cs low", n, EXP_LAT);
    n = 0;
    while (!psram_cs_n && !psram_mode && n < 100) begin n++; step(); end
    check("R3 low hold cycles", n, EXP_LOW);
    n = 0;
    while (psram_cs_n && !psram_mode && n < 100) begin n++; step(); end
    check("R4 cs-high mode-low cycles", n, 1);
    if (early) rsize_ack = 1'b1;
    n = 0;
    while (psram_mode && psram_cs_n && !mset_req && n < 100) begin n++; step(); end
    check(early ? "R7 R5 high hold with early ack" : "R5 high hold cycles", n, EXP_HIGH);
    rsize_ack = 1'b0;
    check("R6 request raised", mset_req, 1);
    check("R8 captured size", rsize_out, sel);
  endtask

  initial begin
    checks    = 0;
    errors    = 0;
    finished  = 1'b0;
    rst_n     = 1'b0;
    pwr_good  = 1'b0;
    rsize_sel = 2'b00;
    rsize_ack = 1'b0;

    repeat (3) step();
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (5) step();
    check_idle("R1 no power-good");

    // Table walk: one full power cycle per entry.
    for (int v = 0; v < 4; v++) begin
      run_up(VECS[v].sel, VECS[v].early);
      rsize_sel = ~VECS[v].sel;
      for (int w = 0; w < int'(VECS[v].wait_cyc); w++) begin
        step();
        check("R6 request held", {mset_req, ready}, 2'b10);
        check("R8 size ignores new select", rsize_out, VECS[v].sel);
      end
      rsize_ack = 1'b1;
      step();
      rsize_ack = 1'b0;
      check("R6 ready after ack", {mset_req, ready}, 2'b01);
      check("R10 ready pins high", {psram_cs_n, psram_mode}, 2'b11);
      check("R8 size held in run", rsize_out, VECS[v].sel);
      pwr_good = 1'b0;
      step();
      step();
      check("R9 ready before sync", ready, 1);
      step();
      check_idle("R9 power loss");
    end

    // Power loss in the middle of the high hold, then a full rerun.
    pwr_good = 1'b1;
    rsize_sel = 2'b10;
    for (int n = 0; n < 30 && !psram_mode; n++) step();
    repeat (5) step();
    pwr_good = 1'b0;
    repeat (EXP_LAT) step();
    check_idle("R9 loss mid hold");
    repeat (3) step();
    run_up(2'b01, 1'b0);
    check("R9 request again", mset_req, 1);

    // Asynchronous reset during the low hold.
    pwr_good = 1'b0;
    repeat (EXP_LAT + 1) step();
    pwr_good = 1'b1;
    for (int n = 0; n < 30 && psram_cs_n; n++) step();
    repeat (2) step();
    rst_n = 1'b0;
    #1;
    check_idle("R1 async reset");
    step();
    rst_n = 1'b1;
    run_up(2'b11, 1'b0);
    rsize_ack = 1'b1;
    step();
    rsize_ack = 1'b0;
    check("R6 ready after reset rerun", ready, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule